// File: doc/BRIEF.md
# Memory-Aware Table Predistorter

This block predistorts a complex baseband stream before it reaches a power amplifier. Each I/Q sample arrives together with its envelope magnitude. A four-tap FIR can smooth that magnitude over the current and recent samples, so that the amplifier's short-term memory (heating that follows past drive levels) steers the correction. The smoothed value is clipped to the magnitude range, and its upper bits address a 64-entry correction table. Each entry is a complex gain that scales both the amplitude and the phase of the sample. The sample is delayed to meet the table output and is multiplied by that gain. The product is rounded and clipped back to the sample width.

The table has a second, write-only port. An external adaptation engine can rewrite entries on it while samples keep flowing. A separate load strobe sets the FIR coefficients, and one input switches the FIR out so that the current magnitude alone addresses the table. A valid flag travels with every sample through a fixed four-cycle pipeline.

Top module: `memlut_predistorter`

## Requirements
- R1: While reset is applied and after its release, `out_valid`, `out_i` and `out_q` are 0 until the first sample comes out.
- R2: After reset every table entry holds the gain (16384, 0), which is unity in Q2.14 format, so each sample leaves unchanged.
- R3: `out_valid` goes high exactly 4 clock edges after the edge that took `in_valid` high, and for one cycle per sample. While `out_valid` is low, `out_i` and `out_q` hold their values.
- R4: When `fir_en` is 0, the table address is `in_mag[15:10]`.
- R5: When `fir_en` is 1, the address is `in_mag[15:10]` taken from F = floor((c0·m0 + c1·m1 + c2·m2 + c3·m3) / 2^14). Here m0 is the current magnitude, m1 to m3 are the magnitudes of the three preceding valid samples (0 after reset), and c0 to c3 are the signed coefficients. After reset c0 = 16384 and the other coefficients are 0.
- R6: A negative F selects address 0. An F above 65535 selects address 63.
- R7: With table gain (gr, gi), the output before scaling is I = in_i·gr − in_q·gi and Q = in_q·gr + in_i·gi.
- R8: Each output component is (value + 8192) shifted right arithmetically by 14, so an exact half rounds toward +infinity.
- R9: Results outside [−32768, 32767] clip to the nearest bound.
- R10: A table write (`tbl_we` with `tbl_addr`, gain in `tbl_re` and `tbl_im`) changes the gain that later samples at that address receive, while samples keep streaming.
- R11: When a write reaches the entry that the datapath reads on the same edge, that read returns the gain held before the write.
- R12: A coefficient load (`coef_we`, index `coef_sel` 0 to 3 selecting c0 to c3, value `coef_val`) applies to samples that enter after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input, signed |
| in_q | input | 16 | Quadrature input, signed |
| in_mag | input | 16 | Envelope magnitude, unsigned |
| fir_en | input | 1 | 1: FIR-smoothed address, 0: current magnitude only |
| coef_we | input | 1 | Coefficient load strobe |
| coef_sel | input | 2 | Coefficient index |
| coef_val | input | 16 | Coefficient value, signed Q2.14 |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table write address |
| tbl_re | input | 16 | Gain real part, signed Q2.14 |
| tbl_im | input | 16 | Gain imaginary part, signed Q2.14 |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Predistorted in-phase output |
| out_q | output | 16 | Predistorted quadrature output |

## Verification
Each table entry in the bench holds a distinct gain, so a wrong address, a wrong history register or a stale coefficient produces an output sample that differs from the model. That difference appears four cycles after the sample that should have selected the entry. A corrupted table word shows on the first sample that reads it. A rounding or clipping fault shows only at the exact half-LSB and overflow corners, so those corners are driven on purpose. A misaligned valid flag shows as a strobe one edge early or late.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

   // rounding variants available to the output scaler
   typedef enum logic {
      RND_FLOOR   = 1'b0,
      RND_HALF_UP = 1'b1
   } rnd_mode_e;

   // value of 1.0 for a fixed-point word with FRAC fractional bits
   function automatic int unsigned fx_one(input int unsigned frac);
      return 32'd1 << frac;
   endfunction

endpackage

// File: rtl/mag_fir_addr.sv
module mag_fir_addr #(
   parameter int MW    = 16,
   parameter int AW    = 6,
   parameter int TAPS  = 4,
   parameter int CW    = 16,
   parameter int CFRAC = 14
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      smp_valid,
   input  logic [MW-1:0]             smp_mag,
   input  logic                      fir_en,
   input  logic                      coef_we,
   input  logic [$clog2(TAPS)-1:0]   coef_sel,
   input  logic signed [CW-1:0]      coef_val,
   output logic [AW-1:0]             tbl_addr
);
   localparam int PW    = MW + 1 + CW;
   localparam int ACC_W = PW + $clog2(TAPS) + 1;
   localparam logic signed [CW-1:0] C_ONE = CW'(dpd_pkg::fx_one(CFRAC));

   logic signed [CW-1:0] coef [TAPS];
   logic [MW-1:0]        hist [TAPS-1];
   logic signed [MW:0]   tap_s [TAPS];
   logic signed [PW-1:0] prod  [TAPS];
   logic signed [ACC_W-1:0] acc, scaled;
   logic [AW-1:0]        addr_nx;

   // coefficient bank
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS; k++) coef[k] <= (k == 0) ? C_ONE : '0;
      end else if (coef_we && (int'(coef_sel) < TAPS)) begin
         coef[coef_sel] <= coef_val;
      end
   end

   // magnitude history, advanced only by valid samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS - 1; k++) hist[k] <= '0;
      end else if (smp_valid) begin
         hist[0] <= smp_mag;
         for (int k = 1; k < TAPS - 1; k++) hist[k] <= hist[k-1];
      end
   end

   genvar g;
   generate
      for (g = 0; g < TAPS; g++) begin : g_tap
         if (g == 0) begin : g_cur
            assign tap_s[g] = signed'({1'b0, smp_mag});
         end else begin : g_old
            assign tap_s[g] = signed'({1'b0, hist[g-1]});
         end
         assign prod[g] = PW'(tap_s[g]) * PW'(coef[g]);
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++) acc = acc + ACC_W'(prod[k]);
      scaled = acc >>> CFRAC;
      if (!fir_en)                   addr_nx = smp_mag[MW-1 -: AW];
      else if (scaled[ACC_W-1])      addr_nx = '0;
      else if (|scaled[ACC_W-2:MW])  addr_nx = '1;
      else                           addr_nx = scaled[MW-1 -: AW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl_addr <= '0;
      else        tbl_addr <= addr_nx;
   end

endmodule

// File: rtl/gain_ram.sv
module gain_ram #(
   parameter int AW    = 6,
   parameter int GW    = 16,
   parameter int GFRAC = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        rd_addr,
   output logic signed [GW-1:0] rd_re,
   output logic signed [GW-1:0] rd_im,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic signed [GW-1:0] wr_re,
   input  logic signed [GW-1:0] wr_im
);
   localparam int DEPTH = 1 << AW;
   localparam logic [2*GW-1:0] UNITY = {GW'(dpd_pkg::fx_one(GFRAC)), {GW{1'b0}}};

   logic [2*GW-1:0] mem [DEPTH];
   logic [2*GW-1:0] rd_q;

   // read port sees the pre-write word on a same-address collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= UNITY;
         rd_q <= UNITY;
      end else begin
         if (wr_en) mem[wr_addr] <= {wr_re, wr_im};
         rd_q <= mem[rd_addr];
      end
   end

   assign rd_re = signed'(rd_q[2*GW-1:GW]);
   assign rd_im = signed'(rd_q[GW-1:0]);

endmodule

// File: rtl/cmul_round.sv
module cmul_round #(
   parameter int DW    = 16,
   parameter int GW    = 16,
   parameter int GFRAC = 14,
   parameter dpd_pkg::rnd_mode_e RND = dpd_pkg::RND_HALF_UP
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic signed [DW-1:0] x_i,
   input  logic signed [DW-1:0] x_q,
   input  logic signed [GW-1:0] g_re,
   input  logic signed [GW-1:0] g_im,
   output logic                 out_vld,
   output logic signed [DW-1:0] y_i,
   output logic signed [DW-1:0] y_q
);
   localparam int PW = DW + GW;
   localparam int SW = PW + 2;

   logic signed [PW-1:0] p_ir, p_qi, p_qr, p_ii;
   logic                 v_p;
   logic signed [SW-1:0] bias, s_re, s_im;

   generate
      if (RND == dpd_pkg::RND_HALF_UP) begin : g_half
         assign bias = {{(SW-GFRAC){1'b0}}, 1'b1, {(GFRAC-1){1'b0}}};
      end else begin : g_floor
         assign bias = '0;
      end
   endgenerate

   function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
      logic signed [SW-1:0] s;
      s = v >>> GFRAC;
      if ((&s[SW-1:DW-1]) || !(|s[SW-1:DW-1])) return s[DW-1:0];
      else if (s[SW-1])                        return {1'b1, {(DW-1){1'b0}}};
      else                                     return {1'b0, {(DW-1){1'b1}}};
   endfunction

   // stage A: four real products
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_p  <= 1'b0;
         p_ir <= '0; p_qi <= '0; p_qr <= '0; p_ii <= '0;
      end else begin
         v_p <= in_vld;
         if (in_vld) begin
            p_ir <= PW'(x_i) * PW'(g_re);
            p_qi <= PW'(x_q) * PW'(g_im);
            p_qr <= PW'(x_q) * PW'(g_re);
            p_ii <= PW'(x_i) * PW'(g_im);
         end
      end
   end

   assign s_re = SW'(p_ir) - SW'(p_qi) + bias;
   assign s_im = SW'(p_qr) + SW'(p_ii) + bias;

   // stage B: combine, round, clip
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         y_i     <= '0;
         y_q     <= '0;
      end else begin
         out_vld <= v_p;
         if (v_p) begin
            y_i <= clip(s_re);
            y_q <= clip(s_im);
         end
      end
   end

endmodule

// File: rtl/memlut_predistorter.sv
module memlut_predistorter #(
   parameter int DW    = 16,
   parameter int MW    = 16,
   parameter int AW    = 6,
   parameter int TAPS  = 4,
   parameter int CW    = 16,
   parameter int CFRAC = 14,
   parameter int GW    = 16,
   parameter int GFRAC = 14,
   parameter dpd_pkg::rnd_mode_e RND = dpd_pkg::RND_HALF_UP
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [DW-1:0]    in_i,
   input  logic signed [DW-1:0]    in_q,
   input  logic [MW-1:0]           in_mag,
   input  logic                    fir_en,
   input  logic                    coef_we,
   input  logic [$clog2(TAPS)-1:0] coef_sel,
   input  logic signed [CW-1:0]    coef_val,
   input  logic                    tbl_we,
   input  logic [AW-1:0]           tbl_addr,
   input  logic signed [GW-1:0]    tbl_re,
   input  logic signed [GW-1:0]    tbl_im,
   output logic                    out_valid,
   output logic signed [DW-1:0]    out_i,
   output logic signed [DW-1:0]    out_q
);
   // elaboration-time parameter checks
   generate
      if (AW > MW)                     begin : g_bad_aw   $error("AW exceeds MW"); end
      if (TAPS < 2)                    begin : g_bad_taps $error("TAPS below 2"); end
      if (CFRAC < 1 || CFRAC > CW - 2) begin : g_bad_cf   $error("CFRAC out of range"); end
      if (GFRAC < 2 || GFRAC > GW - 2) begin : g_bad_gf   $error("GFRAC out of range"); end
   endgenerate

   logic [AW-1:0]        lut_addr;
   logic signed [GW-1:0] lut_re, lut_im;
   logic                 v1, v2;
   logic signed [DW-1:0] i1, q1, i2, q2;

   mag_fir_addr #(.MW(MW), .AW(AW), .TAPS(TAPS), .CW(CW), .CFRAC(CFRAC)) i_addr (
      .clk(clk), .rst_n(rst_n), .smp_valid(in_valid), .smp_mag(in_mag),
      .fir_en(fir_en), .coef_we(coef_we), .coef_sel(coef_sel), .coef_val(coef_val),
      .tbl_addr(lut_addr)
   );

   gain_ram #(.AW(AW), .GW(GW), .GFRAC(GFRAC)) i_ram (
      .clk(clk), .rst_n(rst_n), .rd_addr(lut_addr), .rd_re(lut_re), .rd_im(lut_im),
      .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_re(tbl_re), .wr_im(tbl_im)
   );

   // sample alignment across the address and table stages
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0;
         i1 <= '0; q1 <= '0; i2 <= '0; q2 <= '0;
      end else begin
         v1 <= in_valid;
         v2 <= v1;
         i1 <= in_i; q1 <= in_q;
         i2 <= i1;   q2 <= q1;
      end
   end

   cmul_round #(.DW(DW), .GW(GW), .GFRAC(GFRAC), .RND(RND)) i_mul (
      .clk(clk), .rst_n(rst_n), .in_vld(v2), .x_i(i2), .x_q(q2),
      .g_re(lut_re), .g_im(lut_im),
      .out_vld(out_valid), .y_i(out_i), .y_q(out_q)
   );

endmodule

// File: rtl/memlut_predistorter_chk.sv
module memlut_predistorter_chk #(
   parameter int DW = 16,
   parameter int MW = 16,
   parameter int AW = 6,
   parameter int GW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [MW-1:0]        in_mag,
   input logic                 fir_en,
   input logic [AW-1:0]        rd_addr,
   input logic signed [GW-1:0] rd_re,
   input logic signed [GW-1:0] rd_im,
   input logic                 wr_en,
   input logic [AW-1:0]        wr_addr,
   input logic                 out_valid,
   input logic signed [DW-1:0] out_i,
   input logic signed [DW-1:0] out_q
);
   p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 4));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_i) && $stable(out_q)));

   p_bypass_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fir_en) |=> (rd_addr == $past(in_mag[MW-1 -: AW])));

   p_collide_old_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == rd_addr && $past(rd_addr) == rd_addr && !$past(wr_en))
      |=> ($stable(rd_re) && $stable(rd_im)));

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
endmodule

bind memlut_predistorter memlut_predistorter_chk #(.DW(DW), .MW(MW), .AW(AW), .GW(GW)) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mag(in_mag), .fir_en(fir_en),
   .rd_addr(lut_addr), .rd_re(lut_re), .rd_im(lut_im),
   .wr_en(tbl_we), .wr_addr(tbl_addr),
   .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/test_memlut_predistorter.sv
module test_memlut_predistorter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [15:0] in_i = '0, in_q = '0;
   logic [15:0] in_mag = '0;
   logic fir_en = 1'b1;
   logic coef_we = 1'b0;
   logic [1:0] coef_sel = '0;
   logic signed [15:0] coef_val = '0;
   logic tbl_we = 1'b0;
   logic [5:0] tbl_addr = '0;
   logic signed [15:0] tbl_re = '0, tbl_im = '0;
   logic out_valid;
   logic signed [15:0] out_i, out_q;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state kept by the bench
   longint cm [4];
   longint gre [64];
   longint gim [64];
   longint mh [3];
   bit     fir_m = 1'b1;

   always #10 clk = ~clk;

   memlut_predistorter i_memlut_predistorter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .in_mag(in_mag), .fir_en(fir_en), .coef_we(coef_we), .coef_sel(coef_sel),
      .coef_val(coef_val), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_re(tbl_re),
      .tbl_im(tbl_im), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int m_addr(input longint mag);
      longint acc;
      if (!fir_m) return int'(mag >>> 10);
      acc = cm[0]*mag + cm[1]*mh[0] + cm[2]*mh[1] + cm[3]*mh[2];
      acc = acc >>> 14;
      if (acc < 0) acc = 0;
      if (acc > 65535) acc = 65535;
      return int'(acc >>> 10);
   endfunction

   function automatic longint m_scale(input longint v);
      longint s;
      s = (v + 8192) >>> 14;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return s;
   endfunction

   // one sample through the pipe, with latency and value checks
   task automatic push(input string req, input longint xi, input longint xq, input longint mag);
      int a;
      longint ei, eq;
      a  = m_addr(mag);
      ei = m_scale(xi*gre[a] - xq*gim[a]);
      eq = m_scale(xq*gre[a] + xi*gim[a]);
      mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = mag;
      @(negedge clk);
      in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq); in_mag = 16'(mag);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R3 early valid", longint'(out_valid), 0);
      @(negedge clk);
      chk("R3 valid at 4", longint'(out_valid), 1);
      chk({req, " I"}, longint'(out_i), ei);
      chk({req, " Q"}, longint'(out_q), eq);
      @(negedge clk);
      chk("R3 single strobe", longint'(out_valid), 0);
      chk("R3 hold I", longint'(out_i), ei);
   endtask

   task automatic wr_gain(input int a, input longint re, input longint im);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 6'(a); tbl_re = 16'(re); tbl_im = 16'(im);
      @(negedge clk);
      tbl_we = 1'b0;
      gre[a] = re; gim[a] = im;
   endtask

   task automatic wr_coef(input int k, input longint v);
      @(negedge clk);
      coef_we = 1'b1; coef_sel = 2'(k); coef_val = 16'(v);
      @(negedge clk);
      coef_we = 1'b0;
      cm[k] = v;
   endtask

   task automatic t_reset;
      chk("R1 valid in reset", longint'(out_valid), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 valid", longint'(out_valid), 0);
      chk("R1 out_i", longint'(out_i), 0);
      chk("R1 out_q", longint'(out_q), 0);
   endtask

   task automatic t_unity;
      push("R2 unity", 1000, -2000, 5000);
      push("R2 unity", 32767, -32768, 65535);
      push("R2 unity", -12345, 23456, 40000);
      push("R2 unity zero", 0, 0, 0);
      chk("R2 passthrough", longint'(out_i), 0);
   endtask

   task automatic t_fill;
      for (int k = 0; k < 64; k++) wr_gain(k, 6000 + 300*k, 200*k - 6000);
      push("R10 R7 new gain", 16384, 0, 20*1024);
      push("R7 mixed", -7000, 9000, 33000);
      push("R7 mixed", 12000, 15000, 1500);
   endtask

   task automatic t_fir;
      wr_coef(0, 8192); wr_coef(1, 4096); wr_coef(2, 2048); wr_coef(3, 2048);
      push("R5 R12 fir", 16384, 0, 60000);
      push("R5 fir", 16384, 0, 10000);
      push("R5 fir", 3000, -4000, 30000);
      push("R5 fir", 16384, 0, 50000);
   endtask

   task automatic t_addr_sat;
      wr_coef(0, -16384); wr_coef(1, 0); wr_coef(2, 0); wr_coef(3, 0);
      chk("R6 model low", longint'(m_addr(40000)), 0);
      push("R6 negative to 0", 16384, 0, 40000);
      wr_coef(0, 32767); wr_coef(1, 32767);
      push("R6 prime", 16384, 0, 60000);
      chk("R6 model high", longint'(m_addr(60000)), 63);
      push("R6 over to 63", 16384, 0, 60000);
   endtask

   task automatic t_bypass;
      wr_coef(0, -16384); wr_coef(1, 0);
      @(negedge clk); fir_en = 1'b0; fir_m = 1'b0;
      push("R4 bypass", 16384, 0, 45000);
      push("R4 bypass", 16384, 0, 1023);
      @(negedge clk); fir_en = 1'b1; fir_m = 1'b1;
      wr_coef(0, 16384);
   endtask

   task automatic t_round;
      wr_gain(5, 8192, 0);
      push("R8 half up pos", 1, 0, 5*1024);
      chk("R8 one", longint'(out_i), 1);
      push("R8 half up neg", -1, 0, 5*1024);
      chk("R8 zero", longint'(out_i), 0);
      push("R8 1.5", 3, 0, 5*1024);
   endtask

   task automatic t_clip;
      wr_gain(7, 32767, -32768);
      push("R9 clip low", -32768, -32768, 7*1024);
      chk("R9 min", longint'(out_i), -32768);
      push("R9 clip high", 32767, 32767, 7*1024);
      chk("R9 max", longint'(out_i), 32767);
   endtask

   task automatic t_collide;
      int a;
      longint ei, eq;
      a  = 9;
      ei = m_scale(16384*gre[a]);
      eq = m_scale(16384*gim[a]);
      mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = a*1024;
      @(negedge clk);
      in_valid = 1'b1; in_i = 16'sd16384; in_q = '0; in_mag = 16'(a*1024);
      @(negedge clk);
      in_valid = 1'b0;
      tbl_we = 1'b1; tbl_addr = 6'(a); tbl_re = 16'sd1234; tbl_im = -16'sd4321;
      @(negedge clk);
      tbl_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R11 valid", longint'(out_valid), 1);
      chk("R11 old I", longint'(out_i), ei);
      chk("R11 old Q", longint'(out_q), eq);
      gre[a] = 1234; gim[a] = -4321;
      push("R11 R10 next sees new", 16384, 0, a*1024);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      for (int k = 0; k < 64; k++) begin gre[k] = 16384; gim[k] = 0; end
      cm[0] = 16384; cm[1] = 0; cm[2] = 0; cm[3] = 0;
      mh[0] = 0; mh[1] = 0; mh[2] = 0;
      t_reset;
      t_unity;
      t_fill;
      t_fir;
      t_addr_sat;
      t_bypass;
      t_round;
      t_clip;
      t_collide;
      summary;
   end

   initial begin
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary;
   end
endmodule